// File: doc/BRIEF.md
# Set-Associative Flow Lookup Table

This block turns a hashed flow identifier into a storage location and reports the class recorded for that flow. The identifier splits into a line index and a signature. The line index selects one line of an on-chip table. Each line holds eight records, and each record has a signature, a class, a recency rank and an occupancy bit. Every lookup compares the signature against all records of the selected line in the same cycle. It then reports whether the flow is known or new, where it lives, and what class it carries.

A hit refreshes the recency ranks of the line. A miss claims a free record, or replaces the least recently used record when the line is full. Two side ports maintain the table. An inactivity monitor removes flows by location, and a classifier writes the class of a flow by location. The location is the line index joined to the way number. A downstream statistics memory can therefore use it directly as an address.

Top module: `flow_lookup_table`

## Requirements
- R1: The identifier's upper 10 bits `lk_flow_id[41:32]` select the line and its lower 32 bits are the signature. The result for a request on `lk_valid` appears exactly one clock later with `res_valid` high. `res_loc` is 13 bits wide: the line index in bits 12:3 and the way number in bits 2:0.
- R2: When an occupied record in the line carries the same signature, the result reports that way, the class stored in it, and `res_new` low.
- R3: On a miss with at least one unoccupied record, the lowest-numbered unoccupied way is claimed. The result reports that way with `res_new` high and class 0x00.
- R4: On a miss in a full line, the record with the smallest recency rank is replaced; ties go to the lowest way number. The result reports that way with `res_new` high and class 0x00.
- R5: Each lookup, hit or allocation, sets the accessed record's 3-bit rank to 7 and lowers every other rank in the line by one.
- R6: A rank already at 0 stays at 0 when it is lowered; it never wraps to 7.
- R7: A delete request (`del_valid`, `del_loc`) frees the record at that location. A later lookup of that flow misses, and the freed way can be claimed again.
- R8: A class write (`cw_valid`, `cw_loc`, `cw_class`) replaces the class of the record at that location. Later hits return the new class, and the write leaves the recency ranks unchanged.
- R9: When requests hit the same record in one cycle, a delete overrides the occupancy a lookup would set or keep, and a class write overrides the zero class an allocation would store. A lookup in that cycle reports the table state from before the cycle.
- R10: Reset clears every occupancy bit and drives `res_valid`, `res_new`, `res_loc` and `res_class` to zero.
- R11: In a cycle after one with no lookup request, `res_valid` and `res_new` are low. `res_new` is never high without `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_flow_id | input | 42 | Flow identifier: line index over signature |
| del_valid | input | 1 | Delete request strobe |
| del_loc | input | 13 | Location of the record to free |
| cw_valid | input | 1 | Class write strobe |
| cw_loc | input | 13 | Location of the record whose class is written |
| cw_class | input | 8 | Class value to store |
| res_valid | output | 1 | Lookup result valid |
| res_new | output | 1 | Lookup allocated a new record |
| res_loc | output | 13 | Location of the hit or allocated record |
| res_class | output | 8 | Stored class on a hit, zero on allocation |

## Verification
The hardest state to reach is a full line whose ranks are uneven enough that recency decides the victim. The saturating ranks must also give a different answer than wrapping ranks would. The stimulus fills a single line through a fixed sequence of allocations, hits, a class write and a delete. Along the way it tracks the expected ranks by hand, then misses twice to force two evictions. A final hit lowers a rank that is already zero, and the next miss can only land on the right way if that rank stayed at zero. Same-cycle conflicts are reached by issuing a delete or a class write together with the lookup that touches the same record.

// File: rtl/flut_pkg.sv
package flut_pkg;
   localparam int unsigned FLUT_LINE_BITS  = 10;
   localparam int unsigned FLUT_SIG_BITS   = 32;
   localparam int unsigned FLUT_WAYS       = 8;
   localparam int unsigned FLUT_CLASS_BITS = 8;

   // How a lookup resolved against the indexed line
   typedef enum logic [1:0] {
      LK_HIT   = 2'd0,
      LK_FILL  = 2'd1,
      LK_EVICT = 2'd2
   } lk_kind_e;
endpackage

// File: rtl/flut_match.sv
module flut_match #(
   parameter int unsigned WAYS      = 8,
   parameter int unsigned SIG_BITS  = 32,
   parameter int unsigned RANK_BITS = 3,
   localparam int unsigned WAY_BITS = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][SIG_BITS-1:0]  line_sig,
   input  logic [WAYS-1:0]                line_vld,
   input  logic [WAYS-1:0][RANK_BITS-1:0] line_rank,
   input  logic [SIG_BITS-1:0]            key_sig,
   output logic                           hit,
   output logic [WAY_BITS-1:0]            hit_way,
   output logic                           has_free,
   output logic [WAY_BITS-1:0]            free_way,
   output logic [WAY_BITS-1:0]            victim_way
);
   logic [WAYS-1:0] way_eq;

   // one comparator per way
   for (genvar g = 0; g < WAYS; g++) begin : g_cmp
      assign way_eq[g] = line_vld[g] && (line_sig[g] == key_sig);
   end

   // first matching way
   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (way_eq[i]) begin
            hit     = 1'b1;
            hit_way = WAY_BITS'(i);
         end
      end
   end

   // lowest unoccupied way
   always_comb begin
      has_free = 1'b0;
      free_way = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (!line_vld[i]) begin
            has_free = 1'b1;
            free_way = WAY_BITS'(i);
         end
      end
   end

   // smallest rank, lowest index wins a tie
   always_comb begin
      logic [RANK_BITS-1:0] best;
      best       = line_rank[0];
      victim_way = '0;
      for (int i = 1; i < WAYS; i++) begin
         if (line_rank[i] < best) begin
            best       = line_rank[i];
            victim_way = WAY_BITS'(i);
         end
      end
   end
endmodule

// File: rtl/flut_rank.sv
module flut_rank #(
   parameter int unsigned WAYS      = 8,
   parameter int unsigned RANK_BITS = 3,
   localparam int unsigned WAY_BITS = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][RANK_BITS-1:0] rank_in,
   input  logic [WAY_BITS-1:0]            acc_way,
   output logic [WAYS-1:0][RANK_BITS-1:0] rank_out
);
   localparam logic [RANK_BITS-1:0] RANK_TOP = RANK_BITS'(WAYS - 1);

   for (genvar g = 0; g < WAYS; g++) begin : g_age
      always_comb begin
         if (acc_way == WAY_BITS'(g))
            rank_out[g] = RANK_TOP;
         else if (rank_in[g] == '0)
            rank_out[g] = '0;
         else
            rank_out[g] = rank_in[g] - RANK_BITS'(1);
      end
   end
endmodule

// File: rtl/flow_lookup_table.sv
module flow_lookup_table
   import flut_pkg::*;
#(
   parameter int unsigned LINE_BITS  = FLUT_LINE_BITS,
   parameter int unsigned SIG_BITS   = FLUT_SIG_BITS,
   parameter int unsigned WAYS       = FLUT_WAYS,
   parameter int unsigned CLASS_BITS = FLUT_CLASS_BITS
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  lk_valid,
   input  logic [LINE_BITS+SIG_BITS-1:0]         lk_flow_id,
   input  logic                                  del_valid,
   input  logic [LINE_BITS+$clog2(WAYS)-1:0]     del_loc,
   input  logic                                  cw_valid,
   input  logic [LINE_BITS+$clog2(WAYS)-1:0]     cw_loc,
   input  logic [CLASS_BITS-1:0]                 cw_class,
   output logic                                  res_valid,
   output logic                                  res_new,
   output logic [LINE_BITS+$clog2(WAYS)-1:0]     res_loc,
   output logic [CLASS_BITS-1:0]                 res_class
);
   localparam int unsigned LINES     = 1 << LINE_BITS;
   localparam int unsigned WAY_BITS  = $clog2(WAYS);
   localparam int unsigned RANK_BITS = WAY_BITS;
   localparam int unsigned ID_W      = LINE_BITS + SIG_BITS;
   localparam int unsigned LOC_W     = LINE_BITS + WAY_BITS;

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (LINE_BITS < 1 || LINE_BITS > 12) begin : g_bad_lines
      $error("LINE_BITS must lie in 1..12");
   end
   if (SIG_BITS < 1 || CLASS_BITS < 1) begin : g_bad_fields
      $error("SIG_BITS and CLASS_BITS must be positive");
   end

   // table storage
   logic [SIG_BITS-1:0]   sig_mem  [LINES][WAYS];
   logic [CLASS_BITS-1:0] cls_mem  [LINES][WAYS];
   logic [RANK_BITS-1:0]  rank_mem [LINES][WAYS];
   logic [WAYS-1:0]       vld_q    [LINES];

   // request decode
   logic [LINE_BITS-1:0] lk_line, del_line, cw_line;
   logic [SIG_BITS-1:0]  lk_sig;
   logic [WAY_BITS-1:0]  del_way, cw_way;

   assign lk_line  = lk_flow_id[ID_W-1 -: LINE_BITS];
   assign lk_sig   = lk_flow_id[SIG_BITS-1:0];
   assign del_line = del_loc[LOC_W-1 -: LINE_BITS];
   assign del_way  = del_loc[WAY_BITS-1:0];
   assign cw_line  = cw_loc[LOC_W-1 -: LINE_BITS];
   assign cw_way   = cw_loc[WAY_BITS-1:0];

   // indexed line read-out
   logic [WAYS-1:0][SIG_BITS-1:0]   rd_sig;
   logic [WAYS-1:0][CLASS_BITS-1:0] rd_cls;
   logic [WAYS-1:0][RANK_BITS-1:0]  rd_rank;
   logic [WAYS-1:0]                 rd_vld;

   for (genvar g = 0; g < WAYS; g++) begin : g_rd
      assign rd_sig[g]  = sig_mem[lk_line][g];
      assign rd_cls[g]  = cls_mem[lk_line][g];
      assign rd_rank[g] = rank_mem[lk_line][g];
   end
   assign rd_vld = vld_q[lk_line];

   logic                hit, has_free;
   logic [WAY_BITS-1:0] hit_way, free_way, victim_way, acc_way;
   lk_kind_e            kind;

   flut_match #(
      .WAYS      (WAYS),
      .SIG_BITS  (SIG_BITS),
      .RANK_BITS (RANK_BITS)
   ) i_match (
      .line_sig   (rd_sig),
      .line_vld   (rd_vld),
      .line_rank  (rd_rank),
      .key_sig    (lk_sig),
      .hit        (hit),
      .hit_way    (hit_way),
      .has_free   (has_free),
      .free_way   (free_way),
      .victim_way (victim_way)
   );

   always_comb begin
      if (hit)           kind = LK_HIT;
      else if (has_free) kind = LK_FILL;
      else               kind = LK_EVICT;
      unique case (kind)
         LK_HIT:  acc_way = hit_way;
         LK_FILL: acc_way = free_way;
         default: acc_way = victim_way;
      endcase
   end

   logic [WAYS-1:0][RANK_BITS-1:0] rank_nxt;

   flut_rank #(
      .WAYS      (WAYS),
      .RANK_BITS (RANK_BITS)
   ) i_rank (
      .rank_in  (rd_rank),
      .acc_way  (acc_way),
      .rank_out (rank_nxt)
   );

   // record contents; later assignments take priority
   always_ff @(posedge clk) begin
      if (lk_valid) begin
         for (int w = 0; w < WAYS; w++) rank_mem[lk_line][w] <= rank_nxt[w];
         if (kind != LK_HIT) begin
            sig_mem[lk_line][acc_way] <= lk_sig;
            cls_mem[lk_line][acc_way] <= '0;
         end
      end
      if (cw_valid) cls_mem[cw_line][cw_way] <= cw_class;
   end

   // occupancy; delete is applied last so it wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < LINES; l++) vld_q[l] <= '0;
      end else begin
         if (lk_valid && kind != LK_HIT) vld_q[lk_line][acc_way] <= 1'b1;
         if (del_valid)                  vld_q[del_line][del_way] <= 1'b0;
      end
   end

   // registered result
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_new   <= 1'b0;
         res_loc   <= '0;
         res_class <= '0;
      end else begin
         res_valid <= lk_valid;
         res_new   <= lk_valid && (kind != LK_HIT);
         res_loc   <= lk_valid ? {lk_line, acc_way} : '0;
         res_class <= (lk_valid && kind == LK_HIT) ? rd_cls[hit_way] : '0;
      end
   end
endmodule

// File: rtl/flut_checker.sv
module flut_checker #(
   parameter int unsigned LINE_BITS  = 10,
   parameter int unsigned SIG_BITS   = 32,
   parameter int unsigned WAYS       = 8,
   parameter int unsigned CLASS_BITS = 8,
   localparam int unsigned LOC_W     = LINE_BITS + $clog2(WAYS)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          lk_valid,
   input logic [LINE_BITS+SIG_BITS-1:0] lk_flow_id,
   input logic                          del_valid,
   input logic                          res_valid,
   input logic                          res_new,
   input logic [LOC_W-1:0]              res_loc,
   input logic [CLASS_BITS-1:0]         res_class
);
   localparam int unsigned ID_W = LINE_BITS + SIG_BITS;

   p_result_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid);

   p_line_echo_r1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_loc[LOC_W-1 -: LINE_BITS] == $past(lk_flow_id[ID_W-1 -: LINE_BITS]));

   p_rehit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && $past(lk_valid) && lk_flow_id == $past(lk_flow_id) && !$past(del_valid))
      |=> (!res_new && res_loc == $past(res_loc)));

   p_new_class_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_new) |-> res_class == '0);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!res_valid && !res_new));

   p_new_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      res_new |-> res_valid);
endmodule

bind flow_lookup_table flut_checker #(
   .LINE_BITS  (LINE_BITS),
   .SIG_BITS   (SIG_BITS),
   .WAYS       (WAYS),
   .CLASS_BITS (CLASS_BITS)
) i_flut_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .lk_flow_id (lk_flow_id),
   .del_valid  (del_valid),
   .res_valid  (res_valid),
   .res_new    (res_new),
   .res_loc    (res_loc),
   .res_class  (res_class)
);

// File: tb/test_flow_lookup_table.sv
module test_flow_lookup_table;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [41:0] lk_flow_id = '0;
   logic        del_valid = 1'b0;
   logic [12:0] del_loc = '0;
   logic        cw_valid = 1'b0;
   logic [12:0] cw_loc = '0;
   logic [7:0]  cw_class = '0;
   logic        res_valid, res_new;
   logic [12:0] res_loc;
   logic [7:0]  res_class;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   flow_lookup_table i_flow_lookup_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_valid   (lk_valid),
      .lk_flow_id (lk_flow_id),
      .del_valid  (del_valid),
      .del_loc    (del_loc),
      .cw_valid   (cw_valid),
      .cw_loc     (cw_loc),
      .cw_class   (cw_class),
      .res_valid  (res_valid),
      .res_new    (res_new),
      .res_loc    (res_loc),
      .res_class  (res_class)
   );

   function automatic logic [41:0] fid(int line, logic [31:0] sig);
      return {10'(line), sig};
   endfunction

   function automatic logic [12:0] loc(int line, int way);
      return {10'(line), 3'(way)};
   endfunction

   // stimulus table: identifier, expected location, class, new flag (R1 R2 R3)
   localparam logic [41:0] T_ID [NVEC] = '{
      {10'd5, 32'h11}, {10'd5, 32'h22}, {10'd5, 32'h11},
      {10'd9, 32'h33}, {10'd5, 32'h22}, {10'd9, 32'h11}};
   localparam logic [12:0] T_LOC [NVEC] = '{
      {10'd5, 3'd0}, {10'd5, 3'd1}, {10'd5, 3'd0},
      {10'd9, 3'd0}, {10'd5, 3'd1}, {10'd9, 3'd1}};
   localparam logic [7:0] T_CLS [NVEC] = '{8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
   localparam logic T_NEW [NVEC] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

   task automatic expect_res(input logic [12:0] e_loc, input logic [7:0] e_cls,
                             input logic e_new, input string req);
      checks++;
      if (!(res_valid === 1'b1 && res_loc === e_loc && res_class === e_cls && res_new === e_new)) begin
         fails++;
         $display("FAIL %s: valid=%0b loc=%h class=%h new=%0b expected valid=1 loc=%h class=%h new=%0b",
                  req, res_valid, res_loc, res_class, res_new, e_loc, e_cls, e_new);
      end
   endtask

   // drive at falling edge, result registered at next rising edge, sample at next falling edge
   task automatic lookup(input logic [41:0] id, input logic [12:0] e_loc,
                         input logic [7:0] e_cls, input logic e_new, input string req);
      lk_valid   = 1'b1;
      lk_flow_id = id;
      @(negedge clk);
      lk_valid  = 1'b0;
      del_valid = 1'b0;
      cw_valid  = 1'b0;
      expect_res(e_loc, e_cls, e_new, req);
   endtask

   task automatic delete_at(input logic [12:0] l);
      del_valid = 1'b1;
      del_loc   = l;
      @(negedge clk);
      del_valid = 1'b0;
   endtask

   task automatic write_class(input logic [12:0] l, input logic [7:0] c);
      cw_valid = 1'b1;
      cw_loc   = l;
      cw_class = c;
      @(negedge clk);
      cw_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R10: outputs cleared by reset
      checks++;
      if (res_valid !== 1'b0 || res_new !== 1'b0 || res_loc !== '0 || res_class !== '0) begin
         fails++;
         $display("FAIL R10: valid=%0b new=%0b loc=%h class=%h expected all zero",
                  res_valid, res_new, res_loc, res_class);
      end

      // table walk: R1 R2 R3
      for (int i = 0; i < NVEC; i++)
         lookup(T_ID[i], T_LOC[i], T_CLS[i], T_NEW[i], "R1/R2/R3 table");

      // R11: idle cycle gives no result
      @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_new !== 1'b0) begin
         fails++;
         $display("FAIL R11: valid=%0b new=%0b expected 0 0", res_valid, res_new);
      end

      // R8: class write then hit returns it
      write_class(loc(5, 0), 8'h2A);
      lookup(fid(5, 32'h11), loc(5, 0), 8'h2A, 1'b0, "R8 class write");

      // R7: delete frees way 1, flow misses and reclaims it
      delete_at(loc(5, 1));
      lookup(fid(5, 32'h22), loc(5, 1), 8'h00, 1'b1, "R7 delete");

      // R3: fill remaining ways in order
      for (int w = 2; w < 8; w++)
         lookup(fid(5, 32'h40 + 32'(w - 2)), loc(5, w), 8'h00, 1'b1, "R3 fill");

      // R4 R5 R8: ranks now w0=0 .. w7=7 (class write left ranks alone)
      lookup(fid(5, 32'h99), loc(5, 0), 8'h00, 1'b1, "R4 evict rank 0");
      lookup(fid(5, 32'h11), loc(5, 1), 8'h00, 1'b1, "R5 evict next oldest");
      lookup(fid(5, 32'h45), loc(5, 7), 8'h00, 1'b0, "R2 survivor hit");
      // R6: way 2 and 3 both at 0 only if saturated; wrap would move victim to way 3
      lookup(fid(5, 32'h77), loc(5, 2), 8'h00, 1'b1, "R6 saturation");

      // R9: delete in same cycle as a hit on that record
      del_valid = 1'b1;
      del_loc   = loc(9, 0);
      lookup(fid(9, 32'h33), loc(9, 0), 8'h00, 1'b0, "R9 hit reports prior state");
      lookup(fid(9, 32'h33), loc(9, 0), 8'h00, 1'b1, "R9 delete wins");

      // R9: class write in same cycle as the allocation of that record
      cw_valid = 1'b1;
      cw_loc   = loc(9, 2);
      cw_class = 8'h3C;
      lookup(fid(9, 32'h55), loc(9, 2), 8'h00, 1'b1, "R9 alloc with class write");
      lookup(fid(9, 32'h55), loc(9, 2), 8'h3C, 1'b0, "R9 class write wins");

      // R10: reset empties the table
      do_reset();
      lookup(fid(5, 32'h45), loc(5, 0), 8'h00, 1'b1, "R10 table empty");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule